// File: doc/BRIEF.md
# Oscillator Trim Calibration Controller

This block closes a loop around an on-chip oscillator. It counts cycles of the oscillator's own clock across a measurement window that a slow, trusted reference defines, and compares that count with a programmed target. After every window it moves a 6-bit signed trim code by at most one position. If the oscillator ran too fast, the code steps down. If it ran too slow, the code steps up. A tolerance band around the target leaves the code unchanged, so the loop settles and does not dither.

The reference side supplies one tick per window. The tick passes through a two-flop synchronizer into the oscillator domain, and each synchronized rising edge ends one window and starts the next. The trim code leaves the block on a port and goes to the analog oscillator. The block also raises a lock flag once the loop has settled, a limit flag when a step is requested beyond the end of the code range, and a one-cycle pulse for each evaluated window.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, trim is 000000 (the centre code), and locked, at_limit and win_done are all 0.
- R2: trim is a two's-complement code, with 011111 the fastest setting and 100000 the slowest. On an evaluated window whose count is greater than expect_cnt + tol_cnt, trim decreases by one. On an evaluated window whose count plus tol_cnt is less than expect_cnt, trim increases by one.
- R3: On an evaluated window whose count lies within tol_cnt of expect_cnt (inclusive at both ends), trim keeps its value.
- R4: trim saturates. It never steps from 011111 to 100000 or from 100000 to 011111. at_limit shows whether the most recent evaluated window asked for a step that the end of the range blocked.
- R5: ref_tick passes through two synchronizing flops. Each rising edge that reaches the internal domain closes a window. The window count is the number of clock cycles between two consecutive closes, minus one, so ref_tick rising edges P cycles apart give a count of P-1.
- R6: The first window close after en rises only starts measurement. It produces no win_done pulse and does not change trim.
- R7: While en is 0, ref_tick edges are ignored, no window is evaluated, trim holds its value, and locked reads 0 from the cycle after en falls.
- R8: locked goes to 1 after three consecutive evaluated windows fall within tolerance. It returns to 0 on the first evaluated window outside tolerance.
- R9: The internal cycle counter saturates at its all-ones value and does not wrap. A window longer than 2^CNT_W cycles is judged with a count of 2^CNT_W - 1.
- R10: win_done is a one-cycle pulse for each evaluated window. trim, at_limit and locked change in the same cycle that win_done is high, and trim changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Calibration enable |
| ref_tick | input | 1 | Window tick from the reference domain (asynchronous) |
| expect_cnt | input | CNT_W | Target cycle count per window |
| tol_cnt | input | CNT_W | Allowed deviation from the target |
| trim | output | TRIM_W | Signed trim code driven to the oscillator |
| at_limit | output | 1 | Last evaluated step was blocked at a range end |
| locked | output | 1 | Loop settled within tolerance |
| win_done | output | 1 | Pulse on each evaluated window |

## Verification
The states that are hardest to reach are the two ends of the trim range and a wrapped count. Reaching either end takes dozens of consecutive windows that all push the same way. A wrapped count needs a window longer than the counter can hold. The bench holds the tick period well off target until trim is pinned at each end, then keeps pushing so that the limit flag has to rise while trim stays put. It then uses a 290-cycle window against an 8-bit counter. A wrapping counter would read that window as too slow, while a saturating one reads it as too fast, so the direction of the step tells the two apart. A near-exhaustive sweep of tick periods across the tolerance band checks both band edges, and an enable-off interval with ticks still running checks that the disabled state holds and that the first window after re-enable only re-arms.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clr)                           count_d = '0;
    else if (inc && count_q != CNT_MAX) count_d = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/window_judge.sv
module window_judge
  import osc_trim_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] target,
  input  logic [W-1:0] band,
  output step_e        step
);

  logic [W:0] s_ext, t_ext, b_ext;
  logic       too_fast, too_slow;

  always_comb begin
    s_ext    = {1'b0, sample};
    t_ext    = {1'b0, target};
    b_ext    = {1'b0, band};
    too_fast = s_ext > (t_ext + b_ext);
    too_slow = (s_ext + b_ext) < t_ext;
    if (too_fast)      step = STEP_DOWN;
    else if (too_slow) step = STEP_UP;
    else               step = STEP_HOLD;
  end

endmodule

// File: rtl/trim_stepper.sv
module trim_stepper
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W = 6,
  parameter int LOCK_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              eval,
  input  step_e             step,
  output logic [TRIM_W-1:0] trim,
  output logic              at_limit,
  output logic              locked
);

  localparam int SW = $clog2(LOCK_N + 1);
  localparam logic [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [SW-1:0]     S_TOP = SW'(LOCK_N);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic              lim_q, lim_d;
  logic [SW-1:0]     streak_q, streak_d;

  always_comb begin
    trim_d   = trim_q;
    lim_d    = lim_q;
    streak_d = streak_q;
    if (!en) begin
      streak_d = '0;
    end else if (eval) begin
      lim_d = 1'b0;
      unique case (step)
        STEP_UP: begin
          streak_d = '0;
          if (trim_q == T_MAX) lim_d  = 1'b1;
          else                 trim_d = trim_q + TRIM_W'(1);
        end
        STEP_DOWN: begin
          streak_d = '0;
          if (trim_q == T_MIN) lim_d  = 1'b1;
          else                 trim_d = trim_q - TRIM_W'(1);
        end
        default: begin
          if (streak_q != S_TOP) streak_d = streak_q + SW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q   <= '0;
      lim_q    <= 1'b0;
      streak_q <= '0;
    end else begin
      trim_q   <= trim_d;
      lim_q    <= lim_d;
      streak_q <= streak_d;
    end
  end

  assign trim     = trim_q;
  assign at_limit = lim_q;
  assign locked   = (streak_q == S_TOP);

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_trim_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int TRIM_W = 6,
  parameter int SYNC_N = 2,
  parameter int LOCK_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ref_tick,
  input  logic [CNT_W-1:0]  expect_cnt,
  input  logic [CNT_W-1:0]  tol_cnt,
  output logic [TRIM_W-1:0] trim,
  output logic              at_limit,
  output logic              locked,
  output logic              win_done
);

  logic             tick_rise;
  logic             close_win;
  logic             eval_win;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, armed_d;
  logic             done_q, done_d;
  step_e            step;

  ref_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ref_tick),
    .rise     (tick_rise)
  );

  assign close_win = en & tick_rise;
  assign eval_win  = close_win & armed_q;
  assign cnt_clr   = ~en | close_win;

  sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (en),
    .count (cnt_q)
  );

  window_judge #(.W(CNT_W)) u_judge (
    .sample (cnt_q),
    .target (expect_cnt),
    .band   (tol_cnt),
    .step   (step)
  );

  trim_stepper #(.TRIM_W(TRIM_W), .LOCK_N(LOCK_N)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .eval     (eval_win),
    .step     (step),
    .trim     (trim),
    .at_limit (at_limit),
    .locked   (locked)
  );

  always_comb begin
    armed_d = en ? (armed_q | close_win) : 1'b0;
    done_d  = eval_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  assign win_done = done_q;

endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
  parameter int CNT_W  = 12,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [TRIM_W-1:0] trim,
  input logic              locked,
  input logic              win_done,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              cnt_clr
);

  localparam logic [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};

  // R2: at most one code position per cycle
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (trim == $past(trim)) || (trim == $past(trim) + TRIM_W'(1)) ||
    (trim == $past(trim) - TRIM_W'(1)));

  // R4: no wrap across the range ends
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(trim) == T_MAX) && (trim == T_MIN)) &&
    !(($past(trim) == T_MIN) && (trim == T_MAX)));

  // R10: trim moves only together with win_done
  a_r10_move_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (trim != $past(trim)) |-> win_done);

  // R7: disabled means no evaluation
  a_r7_no_done_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !win_done);

  // R7: lock drops when disabled
  a_r7_unlock_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);

  // R9: counter holds at all ones unless cleared
  a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == {CNT_W{1'b1}}) && !cnt_clr) |=> (cnt_q == {CNT_W{1'b1}}));

endmodule

bind osc_trim_cal osc_trim_cal_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .trim     (trim),
  .locked   (locked),
  .win_done (win_done),
  .cnt_q    (cnt_q),
  .cnt_clr  (cnt_clr)
);

// File: tb/osc_trim_cal_test.sv
module osc_trim_cal_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int TRIM_W     = 6;
  localparam int EXP        = 40;
  localparam int TOL        = 2;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              en;
  logic              ref_tick;
  logic [CNT_W-1:0]  expect_cnt;
  logic [CNT_W-1:0]  tol_cnt;
  logic [TRIM_W-1:0] trim;
  logic              at_limit;
  logic              locked;
  logic              win_done;

  osc_trim_cal #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ref_tick   (ref_tick),
    .expect_cnt (expect_cnt),
    .tol_cnt    (tol_cnt),
    .trim       (trim),
    .at_limit   (at_limit),
    .locked     (locked),
    .win_done   (win_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int cyc = 0;
  int gaps [0:255];
  int wr = 0;
  int rd = 0;
  bit armed_b = 0;
  bit en_b = 0;
  int last_rise = 0;

  int trim_m = 0;
  int streak_m = 0;
  bit lim_m = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int trim_s();
    return int'($signed(trim));
  endfunction

  // Window monitor: model of R2, R3, R4, R5, R8, R9, R10
  always @(negedge clk) begin
    if (rst_n && win_done) begin
      if (rd == wr) begin
        check(1'b0, "R10 unexpected win_done", 1, 0);
      end else begin
        int gap, s;
        bit fast, slow;
        gap = gaps[rd % 256];
        rd++;
        s = gap - 1;
        if (s > CMAX) s = CMAX;        // R9 saturating count
        fast = s > EXP + TOL;
        slow = s + TOL < EXP;
        lim_m = 1'b0;
        if (fast) begin
          streak_m = 0;
          if (trim_m == -32) lim_m = 1'b1; else trim_m--;
        end else if (slow) begin
          streak_m = 0;
          if (trim_m == 31) lim_m = 1'b1; else trim_m++;
        end else if (streak_m < 3) begin
          streak_m++;
        end
        check(trim_s() == trim_m, fast ? "R2 step down" : slow ? "R2 step up" : "R3 hold",
              trim_s(), trim_m);
        check(at_limit == lim_m, "R4 at_limit", int'(at_limit), int'(lim_m));
        check(locked == (streak_m == 3), "R8 locked", int'(locked), int'(streak_m == 3));
      end
    end
  end

  task automatic tick_windows(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      if (en_b) begin
        if (armed_b) begin
          gaps[wr % 256] = cyc - last_rise;
          wr++;
        end
        armed_b = 1'b1;
        last_rise = cyc;
      end
      @(negedge clk);
      for (int j = 0; j < p - 2; j++) begin
        ref_tick = 1'b0;
        @(negedge clk);
      end
      ref_tick = 1'b0;
    end
  endtask

  initial begin
    int held;
    rst_n = 1'b0;
    en = 1'b0;
    ref_tick = 1'b0;
    expect_cnt = CNT_W'(EXP);
    tol_cnt = CNT_W'(TOL);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(trim == '0, "R1 trim", trim_s(), 0);
    check(!locked, "R1 locked", int'(locked), 0);
    check(!at_limit, "R1 at_limit", int'(at_limit), 0);
    check(!win_done, "R1 win_done", int'(win_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1; en_b = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R6: first close arms only, then sweep across the band edges
    tick_windows(41, 1);
    check(trim == '0, "R6 arm only", trim_s(), 0);
    for (int p = 35; p <= 47; p++) tick_windows(p, 3);

    // R8 settle inside the band
    tick_windows(EXP + 1, 4);
    repeat (5) @(negedge clk);
    check(locked, "R8 lock after three", int'(locked), 1);

    // R4 push to the top end and beyond
    tick_windows(20, 45);
    repeat (5) @(negedge clk);
    check(trim_s() == 31, "R4 top end", trim_s(), 31);
    check(at_limit, "R4 limit high", int'(at_limit), 1);

    // R4 push to the bottom end and beyond
    tick_windows(60, 70);
    repeat (5) @(negedge clk);
    check(trim_s() == -32, "R4 bottom end", trim_s(), -32);
    check(at_limit, "R4 limit low", int'(at_limit), 1);

    // R9 long window: saturation reads as too fast
    tick_windows(20, 4);
    tick_windows(290, 2);
    tick_windows(EXP + 1, 1);
    repeat (5) @(negedge clk);

    // R7 disable: ticks ignored, lock cleared, trim held
    tick_windows(EXP + 1, 4);
    repeat (5) @(negedge clk);
    en = 1'b0; en_b = 1'b0; armed_b = 1'b0; streak_m = 0;
    repeat (2) @(negedge clk);
    check(!locked, "R7 unlock", int'(locked), 0);
    held = trim_s();
    tick_windows(20, 6);
    repeat (5) @(negedge clk);
    check(trim_s() == held, "R7 trim held", trim_s(), held);

    // R6 re-enable: first tick only arms
    en = 1'b1; en_b = 1'b1;
    repeat (2) @(negedge clk);
    tick_windows(20, 1);
    repeat (5) @(negedge clk);
    check(trim_s() == held, "R6 rearm only", trim_s(), held);
    tick_windows(20, 3);
    repeat (5) @(negedge clk);
    check(rd == wr, "R10 all windows seen", rd, wr);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog timeout", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule